// File: doc/BRIEF.md
# SMM Memory Window Overlay and Acknowledge Tracker

This block sits in the address decode path of a host bridge and handles the memory window that is reserved for system management code. Each host request carries an address and a flag that says whether the processor is running in management mode. When the window is enabled and the request falls inside it, the block does one of two things. With the management flag set, it tells the bridge to ignore the access, so that the memory controller behind the bridge serves it from the hidden RAM. With the flag clear, it tells the bridge to claim the access. That claim takes priority over the usual forwarding of accesses above the top of main memory.

After reset the window covers the 64 KB legacy video area at 0A0000h. When relocation is selected, software places the window on any 64 KB block and gives its length in 64 KB blocks. The length is held to the range of one to sixteen blocks, which is at most 1 MB.

The block also tracks whether management mode is active. Each SMI acknowledge strobe produces a one-cycle response pulse. The strobe also sets or clears a registered mode-active output, according to the management flag that comes with it. Between acknowledges the output holds its value.

Top module: `smm_overlay_tracker`

## Requirements
- R1: With relocation off, the window covers the single 64 KB block at 0A0000h (0A0000h to 0AFFFFh inclusive).
- R2: When the window is enabled, req_valid is 1 and req_smm is 1, an address inside the window drives ignore_acc=1 and claim_acc=0 in the same cycle.
- R3: When the window is enabled, req_valid is 1 and req_smm is 0, an address inside the window drives claim_acc=1 and ignore_acc=0 in the same cycle.
- R4: tom_fwd equals req_valid AND req_above_tom AND NOT (window enabled AND address inside the window). The window overrides the top-of-memory forward.
- R5: With relocation on, the window starts at cfg_base*64 KB and spans cfg_size blocks of 64 KB. A cfg_size of 0 gives one block.
- R6: A cfg_size above 16 is treated as 16 blocks, so the window never exceeds 1 MB.
- R7: With cfg_en=0 or req_valid=0, both ignore_acc and claim_acc are 0.
- R8: An ack_strobe with req_smm=1 sets smm_active at the next clock edge.
- R9: An ack_strobe with req_smm=0 clears smm_active at the next clock edge. Without an ack_strobe, smm_active keeps its value.
- R10: ack_resp is 1 for exactly the cycle after each cycle in which ack_strobe is 1, and is 0 otherwise.
- R11: During and right after reset, smm_active=0 and ack_resp=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host memory request present |
| req_addr | input | ADDR_W | Host request address |
| req_smm | input | 1 | Request issued in management mode |
| req_above_tom | input | 1 | Address is above top of main memory |
| ack_strobe | input | 1 | SMI acknowledge transaction seen |
| cfg_en | input | 1 | Window enable |
| cfg_reloc | input | 1 | Use the programmed base and size instead of the default window |
| cfg_base | input | ADDR_W-16 | Window base in 64 KB blocks |
| cfg_size | input | SIZE_W | Window length in 64 KB blocks |
| ignore_acc | output | 1 | Bridge must not claim; memory controller serves |
| claim_acc | output | 1 | Bridge claims the normal-mode access |
| tom_fwd | output | 1 | Above-top-of-memory forward, suppressed by a window hit |
| smm_active | output | 1 | Registered management-mode active indication |
| ack_resp | output | 1 | One-cycle acknowledge response |

## Verification
The bench builds the block with ADDR_W=32, SIZE_W=6 and relocation enabled. A 6-bit size field can hold values from 0 up to 63, so the bench can drive the zero-length case, the exact sixteen-block limit and values far above the clamp. The 32-bit address lets windows be placed well above the legacy area, where the top-of-memory override can be seen. The vector table checks window edges one byte inside and one byte outside each boundary. Directed sequences then check the sticky set and clear of the mode flag and the response pulse on back-to-back acknowledges.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int GRAN_SHIFT   = 16;
  localparam int MAX_BLOCKS   = 16;
  localparam int DEF_BASE_BLK = 'hA;

  function automatic logic [4:0] clamp_blocks(input logic [7:0] sz);
    if (sz == 8'd0)                    return 5'd1;
    else if (sz > 8'(MAX_BLOCKS))      return 5'(MAX_BLOCKS);
    else                               return sz[4:0];
  endfunction

  function automatic logic in_window(input logic [47:0] blk,
                                     input logic [47:0] base,
                                     input logic [4:0]  nblk);
    logic [48:0] lim;
    lim = {1'b0, base} + 49'(nblk);
    return ({1'b0, blk} >= {1'b0, base}) && ({1'b0, blk} < lim);
  endfunction
endpackage

// File: rtl/smm_window_decode.sv
module smm_window_decode
  import smm_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int SIZE_W   = 6,
  parameter bit RELOC_EN = 1'b1,
  localparam int BLK_W   = ADDR_W - GRAN_SHIFT
)(
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_reloc,
  input  logic [BLK_W-1:0]  cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic              win_hit
);
  logic [BLK_W-1:0] req_blk;
  logic [BLK_W-1:0] eff_base;
  logic [4:0]       eff_nblk;

  assign req_blk = req_addr[ADDR_W-1:GRAN_SHIFT];

  generate
    if (RELOC_EN) begin : g_reloc
      always_comb begin
        if (cfg_reloc) begin
          eff_base = cfg_base;
          eff_nblk = clamp_blocks(8'(cfg_size));
        end else begin
          eff_base = BLK_W'(DEF_BASE_BLK);
          eff_nblk = 5'd1;
        end
      end
    end else begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = ^{cfg_reloc, cfg_base, cfg_size};
      assign eff_base   = BLK_W'(DEF_BASE_BLK);
      assign eff_nblk   = 5'd1;
    end
  endgenerate

  assign win_hit = in_window(48'(req_blk), 48'(eff_base), eff_nblk);
endmodule

// File: rtl/smm_ack_tracker.sv
module smm_ack_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_strobe,
  input  logic ack_smm,
  output logic smm_active,
  output logic ack_resp
);
  logic set_ev, clr_ev;
  assign set_ev = ack_strobe &  ack_smm;
  assign clr_ev = ack_strobe & ~ack_smm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smm_active <= 1'b0;
      ack_resp   <= 1'b0;
    end else begin
      ack_resp <= ack_strobe;
      if (set_ev)      smm_active <= 1'b1;
      else if (clr_ev) smm_active <= 1'b0;
    end
  end

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> smm_active);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !smm_active);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_strobe |=> $stable(smm_active));
  p_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |=> ack_resp);
  p_noresp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_strobe |=> !ack_resp);
endmodule

// File: rtl/smm_overlay_tracker.sv
module smm_overlay_tracker
  import smm_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int SIZE_W   = 6,
  parameter bit RELOC_EN = 1'b1,
  localparam int BLK_W   = ADDR_W - GRAN_SHIFT
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  input  logic              req_above_tom,
  input  logic              ack_strobe,
  input  logic              cfg_en,
  input  logic              cfg_reloc,
  input  logic [BLK_W-1:0]  cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic              ignore_acc,
  output logic              claim_acc,
  output logic              tom_fwd,
  output logic              smm_active,
  output logic              ack_resp
);
  logic win_hit;
  logic win_sel;

  smm_window_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .RELOC_EN(RELOC_EN)
  ) u_decode (
    .req_addr (req_addr),
    .cfg_reloc(cfg_reloc),
    .cfg_base (cfg_base),
    .cfg_size (cfg_size),
    .win_hit  (win_hit)
  );

  assign win_sel    = req_valid & cfg_en & win_hit;
  assign ignore_acc = win_sel &  req_smm;
  assign claim_acc  = win_sel & ~req_smm;
  assign tom_fwd    = req_valid & req_above_tom & ~(cfg_en & win_hit);

  smm_ack_tracker u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_strobe(ack_strobe),
    .ack_smm   (req_smm),
    .smm_active(smm_active),
    .ack_resp  (ack_resp)
  );

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ignore_acc && claim_acc));
  p_override_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_acc || claim_acc) |-> !tom_fwd);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !cfg_en) |-> !(ignore_acc || claim_acc));
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (!smm_active && !ack_resp));
endmodule

// File: tb/smm_overlay_tracker_bench.sv
module smm_overlay_tracker_bench;
  localparam int AW = 32;
  localparam int SW = 6;
  localparam int BW = AW - 16;
  localparam int VW = 1 + 1 + BW + SW + AW + 1 + 1 + 3;
  localparam int NV = 17;

  // fields: en, reloc, base, size, addr, smm, above_tom, {exp_ignore, exp_claim, exp_tom}
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b1,1'b0,16'h0000,6'd0, 32'h000A_0000,1'b1,1'b0,3'b100}, // R1 R2 low edge
    {1'b1,1'b0,16'h0000,6'd0, 32'h000A_FFFF,1'b0,1'b0,3'b010}, // R1 R3 high edge
    {1'b1,1'b0,16'h0000,6'd0, 32'h000B_0000,1'b1,1'b0,3'b000}, // R1 above
    {1'b1,1'b0,16'h0000,6'd0, 32'h0009_FFFF,1'b1,1'b0,3'b000}, // R1 below
    {1'b0,1'b0,16'h0000,6'd0, 32'h000A_0000,1'b1,1'b0,3'b000}, // R7 disabled
    {1'b1,1'b1,16'h1000,6'd2, 32'h1001_FFFF,1'b0,1'b1,3'b010}, // R4 R5 override
    {1'b1,1'b1,16'h1000,6'd2, 32'h1002_0000,1'b0,1'b1,3'b001}, // R4 R5 past end
    {1'b1,1'b1,16'h1000,6'd2, 32'h0FFF_FFFF,1'b1,1'b1,3'b001}, // R5 before base
    {1'b1,1'b1,16'h1000,6'd2, 32'h1000_0000,1'b1,1'b1,3'b100}, // R2 R4 smm above tom
    {1'b1,1'b1,16'h2000,6'd40,32'h200F_FFFF,1'b1,1'b0,3'b100}, // R6 clamp inside
    {1'b1,1'b1,16'h2000,6'd40,32'h2010_0000,1'b1,1'b0,3'b000}, // R6 clamp outside
    {1'b1,1'b1,16'h3000,6'd0, 32'h3000_0000,1'b1,1'b0,3'b100}, // R5 size zero
    {1'b1,1'b1,16'h3000,6'd0, 32'h3001_0000,1'b1,1'b0,3'b000}, // R5 size zero end
    {1'b1,1'b1,16'h4000,6'd16,32'h400F_FFFF,1'b0,1'b1,3'b010}, // R6 exact limit
    {1'b0,1'b1,16'h1000,6'd2, 32'h1000_0000,1'b0,1'b1,3'b001}, // R4 R7 disabled
    {1'b1,1'b1,16'h000A,6'd63,32'h0019_FFFF,1'b0,1'b0,3'b010}, // R6 max field
    {1'b1,1'b1,16'h000A,6'd63,32'h001A_0000,1'b0,1'b0,3'b000}  // R6 max field end
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_smm, req_above_tom, ack_strobe, cfg_en, cfg_reloc;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] cfg_base;
  logic [SW-1:0] cfg_size;
  logic ignore_acc, claim_acc, tom_fwd, smm_active, ack_resp;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  smm_overlay_tracker #(.ADDR_W(AW), .SIZE_W(SW), .RELOC_EN(1'b1)) u_smm_overlay_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_smm(req_smm), .req_above_tom(req_above_tom), .ack_strobe(ack_strobe),
    .cfg_en(cfg_en), .cfg_reloc(cfg_reloc), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .ignore_acc(ignore_acc), .claim_acc(claim_acc), .tom_fwd(tom_fwd),
    .smm_active(smm_active), .ack_resp(ack_resp)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ack(input logic smm);
    @(negedge clk);
    ack_strobe = 1'b1; req_smm = smm;
    @(negedge clk);
    ack_strobe = 1'b0; req_smm = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_smm = 1'b0;
    req_above_tom = 1'b0; ack_strobe = 1'b1; cfg_en = 1'b0; cfg_reloc = 1'b0;
    cfg_base = '0; cfg_size = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset", {1'b0, smm_active, ack_resp}, 3'b000);
    ack_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {1'b0, smm_active, ack_resp}, 3'b000);

    req_valid = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      @(negedge clk);
      {cfg_en, cfg_reloc, cfg_base, cfg_size, req_addr, req_smm, req_above_tom} = v[VW-1:3];
      #5;
      chk($sformatf("R1-vector %0d (R2 R3 R4 R5 R6 R7)", i),
          {ignore_acc, claim_acc, tom_fwd}, v[2:0]);
    end

    // R7: no valid request, window hit and above tom
    @(negedge clk);
    cfg_en = 1'b1; cfg_reloc = 1'b0; req_addr = 32'h000A_1234; req_smm = 1'b1;
    req_above_tom = 1'b1; req_valid = 1'b0;
    #5;
    chk("R7 req_valid low", {ignore_acc, claim_acc, tom_fwd}, 3'b000);
    req_valid = 1'b0; req_smm = 1'b0; req_above_tom = 1'b0;

    // R8, R10: set
    @(negedge clk);
    ack_strobe = 1'b1; req_smm = 1'b1;
    #5;
    chk("R8 before edge", {1'b0, smm_active, ack_resp}, 3'b000);
    @(negedge clk);
    ack_strobe = 1'b0; req_smm = 1'b0;
    chk("R8 R10 set and pulse", {1'b0, smm_active, ack_resp}, 3'b011);
    @(negedge clk);
    chk("R9 R10 hold and pulse end", {1'b0, smm_active, ack_resp}, 3'b010);
    repeat (3) @(negedge clk);
    chk("R9 hold", {1'b0, smm_active, ack_resp}, 3'b010);

    // R9: ack with smm set again keeps it, then clear
    ack(1'b1);
    chk("R8 set again", {1'b0, smm_active, ack_resp}, 3'b011);
    ack(1'b0);
    chk("R9 clear", {1'b0, smm_active, ack_resp}, 3'b001);
    @(negedge clk);
    chk("R9 stays clear", {1'b0, smm_active, ack_resp}, 3'b000);

    // R10: back to back strobes, set then clear
    @(negedge clk);
    ack_strobe = 1'b1; req_smm = 1'b1;
    @(negedge clk);
    chk("R10 first of pair", {1'b0, smm_active, ack_resp}, 3'b011);
    req_smm = 1'b0;
    @(negedge clk);
    ack_strobe = 1'b0;
    chk("R10 R9 second of pair", {1'b0, smm_active, ack_resp}, 3'b001);
    @(negedge clk);
    chk("R10 pair ended", {1'b0, smm_active, ack_resp}, 3'b000);

    // R11: reset clears an active flag
    ack(1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears active", {1'b0, smm_active, ack_resp}, 3'b000);
    rst_n = 1'b1;

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule